// File: doc/BRIEF.md
# Next-PC Predictor Without Valid Bits

This block predicts the next fetch address for a single-issue, in-order pipeline in which instruction fetch spans two stages and branches resolve in decode. A direct-mapped table is read with the current fetch PC. It returns a next-PC prediction combinationally in the same cycle, so the first instruction-cache stage can steer the following fetch. Each entry holds only a tag and a next-PC. There is no valid bit. An entry that should not redirect fetch stores its own PC+4, so a hit on that entry gives the same result as a miss.

Decode gives the block the resolved branch and the next-PC that fetch actually followed. The block computes the correct successor and rewrites the entry. When the followed address was wrong, it raises a redirect with the correct address, and the pipeline squashes the two younger fetch slots. After reset, a sweep rewrites every entry so that each one predicts sequential flow. Fetch waits for the sweep to finish.

Top module: `npc_predictor`

## Requirements
- R1: The table index is `fetch_pc[IDX_W+1:2]` and the tag is `fetch_pc[PC_W-1:IDX_W+2]`. Two PCs that share an index but differ in tag occupy one entry, and the most recent write owns it.
- R2: When the stored tag equals the fetch PC's tag, `pred_npc` equals the stored next-PC in the same cycle, with no clock edge in between.
- R3: When the stored tag differs from the fetch PC's tag, `pred_npc` equals `fetch_pc + 4`, wrapping modulo 2^PC_W.
- R4: A synchronous reset raises `init_busy`. The block then holds `init_busy` high for exactly DEPTH = 2^IDX_W cycles after reset is released and keeps it low afterwards. The sweep writes entry i with tag 0 and next-PC i*4+4, so every PC predicts PC+4 after any reset, including PCs whose tag is 0.
- R5: A decoded branch rewrites its entry with its own tag. The stored next-PC is the target when the branch is taken and PC+4 when it is not taken.
- R6: When a decode write and a lookup address the same entry in one cycle, the lookup returns the contents from before the write. The new contents are visible from the next cycle.
- R7: With `dec_valid` high, the resolved next-PC is the target for a taken branch and PC+4 otherwise. `redirect` is high in that same cycle exactly when the resolved next-PC differs from `dec_followed_npc`, and `redirect_pc` then carries the resolved next-PC.
- R8: While `init_busy` is high, decode inputs are ignored. The block raises no redirect and writes no entry.
- R9: A non-branch whose followed next-PC was not PC+4 raises a redirect to PC+4 and rewrites its entry to predict PC+4. A non-branch that was followed correctly writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the table sweep |
| fetch_pc | input | PC_W | PC in the first instruction-cache stage |
| pred_npc | output | PC_W | Predicted next fetch address, same cycle |
| init_busy | output | 1 | High while the sweep runs; fetch must wait |
| dec_valid | input | 1 | Decode holds a valid instruction |
| dec_pc | input | PC_W | PC of the instruction in decode |
| dec_is_branch | input | 1 | The decoded instruction is a branch |
| dec_taken | input | 1 | Resolved direction of the branch |
| dec_target | input | PC_W | Resolved branch target |
| dec_followed_npc | input | PC_W | Next-PC that fetch used after this instruction |
| redirect | output | 1 | Mispredict: squash two younger fetch slots |
| redirect_pc | output | PC_W | Correct next-PC when `redirect` is high |

## Verification
The lookup and the decode write can hit the same table entry in the same clock cycle. The bench provokes this by resolving a branch at PC X while it presents X, or another PC with the same index, as the fetch address. It then expects the old prediction in that cycle and the new one in the next cycle. The sweep and a decode update can also overlap. The bench holds a mispredicting decode request for the whole sweep. It expects no redirect, and after the sweep it expects that PC to predict PC+4.

// File: rtl/npc_pred_pkg.sv
package npc_pred_pkg;
  typedef enum logic {
    SWEEP_RUN  = 1'b1,
    SWEEP_IDLE = 1'b0
  } sweep_state_e;
endpackage

// File: rtl/npc_sweep.sv
module npc_sweep #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy,
  output logic [IDX_W-1:0] sw_idx,
  output logic [PC_W-1:0]  sw_npc
);
  import npc_pred_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  sweep_state_e state_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SWEEP_RUN;
      cnt_q   <= '0;
    end else if (state_q == SWEEP_RUN) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) state_q <= SWEEP_IDLE;
    end
  end

  assign busy   = (state_q == SWEEP_RUN);
  assign sw_idx = cnt_q;
  // entry i maps to address i*4 with tag 0; store that address plus 4
  assign sw_npc = PC_W'({cnt_q, 2'b00}) + PC_W'(4);
endmodule

// File: rtl/npc_table.sv
module npc_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [PC_W-IDX_W-3:0]     wtag,
  input  logic [PC_W-1:0]           wnpc,
  input  logic [IDX_W-1:0]          ridx,
  output logic [PC_W-IDX_W-3:0]     rtag,
  output logic [PC_W-1:0]           rnpc
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PC_W-1:0]  npc_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx] <= wtag;
      npc_mem[widx] <= wnpc;
    end
  end

  assign rtag = tag_mem[ridx];
  assign rnpc = npc_mem[ridx];
endmodule

// File: rtl/npc_resolve.sv
module npc_resolve #(
  parameter int PC_W = 32
) (
  input  logic            busy,
  input  logic            dec_valid,
  input  logic [PC_W-1:0] dec_pc,
  input  logic            dec_is_branch,
  input  logic            dec_taken,
  input  logic [PC_W-1:0] dec_target,
  input  logic [PC_W-1:0] dec_followed_npc,
  output logic            mispredict,
  output logic            upd_en,
  output logic [PC_W-1:0] resolved_npc
);
  logic live;

  always_comb begin
    live         = dec_valid && !busy;
    resolved_npc = (dec_is_branch && dec_taken) ? dec_target : dec_pc + PC_W'(4);
    mispredict   = live && (resolved_npc != dec_followed_npc);
    upd_en       = live && (dec_is_branch || mispredict);
  end
endmodule

// File: rtl/npc_predictor.sv
module npc_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_npc,
  output logic            init_busy,
  input  logic            dec_valid,
  input  logic [PC_W-1:0] dec_pc,
  input  logic            dec_is_branch,
  input  logic            dec_taken,
  input  logic [PC_W-1:0] dec_target,
  input  logic [PC_W-1:0] dec_followed_npc,
  output logic            redirect,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int TAG_W = PC_W - IDX_W - 2;
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_W + 2;

  logic [IDX_W-1:0] sw_idx;
  logic [PC_W-1:0]  sw_npc;
  logic             upd_en;
  logic [PC_W-1:0]  resolved_npc;
  logic             mispredict;

  logic             tbl_we;
  logic [IDX_W-1:0] tbl_widx;
  logic [TAG_W-1:0] tbl_wtag;
  logic [PC_W-1:0]  tbl_wnpc;
  logic [TAG_W-1:0] rd_tag;
  logic [PC_W-1:0]  rd_npc;
  logic             pred_hit;

  npc_sweep #(.PC_W(PC_W), .IDX_W(IDX_W)) sweep_i (
    .clk(clk), .rst(rst), .busy(init_busy), .sw_idx(sw_idx), .sw_npc(sw_npc)
  );

  npc_resolve #(.PC_W(PC_W)) resolve_i (
    .busy(init_busy), .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_is_branch(dec_is_branch), .dec_taken(dec_taken),
    .dec_target(dec_target), .dec_followed_npc(dec_followed_npc),
    .mispredict(mispredict), .upd_en(upd_en), .resolved_npc(resolved_npc)
  );

  // sweep owns the write port until it finishes
  always_comb begin
    if (init_busy) begin
      tbl_we   = 1'b1;
      tbl_widx = sw_idx;
      tbl_wtag = '0;
      tbl_wnpc = sw_npc;
    end else begin
      tbl_we   = upd_en;
      tbl_widx = dec_pc[IDX_LO +: IDX_W];
      tbl_wtag = dec_pc[TAG_LO +: TAG_W];
      tbl_wnpc = resolved_npc;
    end
  end

  npc_table #(.PC_W(PC_W), .IDX_W(IDX_W)) table_i (
    .clk(clk), .we(tbl_we), .widx(tbl_widx), .wtag(tbl_wtag), .wnpc(tbl_wnpc),
    .ridx(fetch_pc[IDX_LO +: IDX_W]), .rtag(rd_tag), .rnpc(rd_npc)
  );

  assign pred_hit    = (rd_tag == fetch_pc[TAG_LO +: TAG_W]);
  assign pred_npc    = pred_hit ? rd_npc : fetch_pc + PC_W'(4);
  assign redirect    = mispredict;
  assign redirect_pc = resolved_npc;
endmodule

// File: rtl/npc_predictor_chk.sv
module npc_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] pred_npc,
  input logic            init_busy,
  input logic [PC_W-1:0] dec_pc,
  input logic [PC_W-1:0] dec_followed_npc,
  input logic            redirect,
  input logic [PC_W-1:0] redirect_pc,
  input logic            pred_hit,
  input logic            tbl_we,
  input logic [PC_W-1:0] tbl_wnpc
);
  // R3
  miss_seq_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> pred_npc == fetch_pc + PC_W'(4));

  // R7
  redir_differs_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> redirect_pc != dec_followed_npc);

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !redirect);

  // R4
  busy_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> init_busy);

  // R4
  busy_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
    !init_busy |=> !init_busy);

  // R6
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tbl_we && !init_busy) && fetch_pc == $past(dec_pc)) |-> pred_npc == $past(tbl_wnpc));
endmodule

bind npc_predictor npc_predictor_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_npc(pred_npc),
  .init_busy(init_busy), .dec_pc(dec_pc), .dec_followed_npc(dec_followed_npc),
  .redirect(redirect), .redirect_pc(redirect_pc), .pred_hit(pred_hit),
  .tbl_we(tbl_we), .tbl_wnpc(tbl_wnpc)
);

// File: tb/npc_predictor_tb_top.sv
module npc_predictor_tb_top;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  typedef struct packed {
    logic        dv;
    logic [31:0] dpc;
    logic        br;
    logic        tk;
    logic [31:0] tgt;
    logic [31:0] fol;
    logic [31:0] lpc;
    logic [31:0] exp_pred;
    logic        exp_red;
    logic [31:0] exp_rpc;
  } vec_t;

  // index = pc[5:2], tag = pc[31:6]
  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h1000, 32'h1004, 1'b0, 32'h0},        // R3 miss
    '{1'b1, 32'h1008, 1'b1, 1'b1, 32'h2000, 32'h100C, 32'h1008, 32'h100C, 1'b1, 32'h2000}, // R6/R7
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h1008, 32'h2000, 1'b0, 32'h0},        // R2/R5 taken
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h2008, 32'h200C, 1'b0, 32'h0},        // R1 other tag
    '{1'b1, 32'h1008, 1'b1, 1'b1, 32'h2000, 32'h2000, 32'h1000, 32'h1004, 1'b0, 32'h0}, // R7 correct
    '{1'b1, 32'h1008, 1'b1, 1'b0, 32'h2000, 32'h2000, 32'h1008, 32'h2000, 1'b1, 32'h100C}, // R6/R7 not taken
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h1008, 32'h100C, 1'b0, 32'h0},        // R5 not-taken stored
    '{1'b1, 32'h1014, 1'b0, 1'b0, 32'h0, 32'h1018, 32'h103C, 32'h1040, 1'b0, 32'h0},  // R9 clean non-branch
    '{1'b1, 32'h2008, 1'b1, 1'b1, 32'h3000, 32'h200C, 32'h2008, 32'h200C, 1'b1, 32'h3000}, // R1/R6
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h1008, 32'h100C, 1'b0, 32'h0},        // R1 evicted
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h2008, 32'h3000, 1'b0, 32'h0},        // R2 new owner
    '{1'b1, 32'h2008, 1'b0, 1'b0, 32'h0, 32'h3000, 32'h2008, 32'h3000, 1'b1, 32'h200C}, // R9 stale non-branch
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h2008, 32'h200C, 1'b0, 32'h0},        // R9 rewritten
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0010, 32'h0014, 1'b0, 32'h0},        // R4 tag-zero hit
    '{1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 32'hFFFFFFFC, 32'h0, 1'b0, 32'h0}        // R3 wrap
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [PC_W-1:0] pred_npc;
  logic            init_busy;
  logic            dec_valid = 1'b0;
  logic [PC_W-1:0] dec_pc = '0;
  logic            dec_is_branch = 1'b0;
  logic            dec_taken = 1'b0;
  logic [PC_W-1:0] dec_target = '0;
  logic [PC_W-1:0] dec_followed_npc = '0;
  logic            redirect;
  logic [PC_W-1:0] redirect_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  npc_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_npc(pred_npc),
    .init_busy(init_busy), .dec_valid(dec_valid), .dec_pc(dec_pc),
    .dec_is_branch(dec_is_branch), .dec_taken(dec_taken),
    .dec_target(dec_target), .dec_followed_npc(dec_followed_npc),
    .redirect(redirect), .redirect_pc(redirect_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    dec_valid        = v.dv;
    dec_pc           = v.dpc;
    dec_is_branch    = v.br;
    dec_taken        = v.tk;
    dec_target       = v.tgt;
    dec_followed_npc = v.fol;
    fetch_pc         = v.lpc;
  endtask

  task automatic idle_dec();
    dec_valid = 1'b0;
    dec_is_branch = 1'b0;
    dec_taken = 1'b0;
  endtask

  task automatic reset_and_sweep(input bit noisy);
    int busy_cycles;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // decode request that would mispredict during the sweep
    dec_valid = noisy; dec_pc = 32'h1008; dec_is_branch = 1'b1; dec_taken = 1'b1;
    dec_target = 32'h2000; dec_followed_npc = 32'h100C;
    rst = 1'b0;
    busy_cycles = 0;
    for (int k = 0; k < 100; k++) begin
      #1;
      if (!init_busy) break;
      busy_cycles++;
      if (redirect) begin
        n_chk++; n_bad++;
        $display("FAIL R8: actual redirect 1 expected 0 during sweep");
      end
      @(negedge clk);
    end
    check("R4 busy length", busy_cycles, DEPTH);
    idle_dec();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state
    @(negedge clk); #1;
    check("R4 busy in reset", init_busy, 1);
    check("R8 no redirect in reset", redirect, 0);

    reset_and_sweep(1'b1);

    // R8: decode held during sweep wrote nothing
    @(negedge clk);
    fetch_pc = 32'h1008; #1;
    check("R8 ignored update", pred_npc, 32'h100C);
    fetch_pc = 32'h0; #1;
    check("R4 swept entry 0", pred_npc, 32'h4);
    fetch_pc = 32'h3C; #1;
    check("R4 swept entry 15", pred_npc, 32'h40);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check($sformatf("vec %0d pred", i), pred_npc, VEC[i].exp_pred);
      check($sformatf("R7 vec %0d redirect", i), redirect, VEC[i].exp_red);
      if (VEC[i].exp_red)
        check($sformatf("R7 vec %0d redirect_pc", i), redirect_pc, VEC[i].exp_rpc);
    end

    // R4: a taken entry is cleared by a later reset
    @(negedge clk);
    dec_valid = 1'b1; dec_pc = 32'h8; dec_is_branch = 1'b1; dec_taken = 1'b1;
    dec_target = 32'h500; dec_followed_npc = 32'hC; fetch_pc = 32'h8;
    @(negedge clk);
    idle_dec(); #1;
    check("R5 tag-zero taken", pred_npc, 32'h500);
    reset_and_sweep(1'b0);
    @(negedge clk);
    fetch_pc = 32'h8; #1;
    check("R4 sweep clears taken", pred_npc, 32'hC);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule